// File: doc/BRIEF.md
# DMA Request Status Tracker

This block sits beside one DMA channel. It watches an asynchronous external request line and keeps a sticky "request pending" status bit that software can poll at any time. The request line passes through a two-flop synchronizer, and a rising edge on the synchronized level is what counts as a request. In handshake mode, a rising edge seen while the pending bit is clear sets the bit at once. In no-handshake mode, the same edge first loads a programmable wait counter. The pending bit stays clear until that counter runs out, even though the request is already there.

A status write strobe clears the pending bit and nothing else. If a status write and a setting event land in the same cycle, the setting event wins, so no request is lost.

The block also tracks a two-buffer ping-pong scheme. It keeps a buffer-state field (none, one loaded, both loaded) and a next-buffer flag naming the slot that software fills next. The active buffer index is decoded from both of them together.

Top module: `dreq_status_tracker`

## Requirements
- R1: In handshake mode (`hs_mode`=1), after `req_in` rises while `req_pending` is clear, `req_pending` reads 0 after the second rising clock edge and 1 after the third.
- R2: When `buf_state` is 01 (one buffer loaded), `active_buf` is the inverse of `next_flag`.
- R3: When `buf_state` is 10 (both buffers loaded), `active_buf` equals `next_flag`.
- R4: When `buf_state` is 00 (no buffer), `active_buf` is 0 and `no_active` is 1; otherwise `no_active` is 0.
- R5: A `buf_load` pulse has these effects: from state 00 it moves to 01, from state 01 it moves to 10, and in both cases it toggles `next_flag`; in state 10 it is ignored. A `buf_done` pulse moves state 10 to 01 and state 01 to 00, and leaves `next_flag` alone. When both pulse together, `buf_done` is applied first and `buf_load` second.
- R6: A `stat_wr` pulse clears `req_pending` on the next edge. If a setting event occurs in the same cycle, `req_pending` is set instead.
- R7: A `stat_wr` pulse leaves `req_sync`, `buf_state`, `next_flag` and `active_buf` unchanged.
- R8: A request line that stays high after a clear does not set `req_pending` again; only a new rising edge does.
- R9: In no-handshake mode (`hs_mode`=0) with `wait_cnt`=W, `req_pending` reads 0 through the (3+W)-th edge after `req_in` rises and 1 after the (4+W)-th edge, while `req_sync` already reads 1.
- R10: After reset, `req_pending`=0, `req_sync`=0, `buf_state`=00, `next_flag`=0, `active_buf`=0 and `no_active`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_in | input | 1 | Asynchronous external DMA request |
| hs_mode | input | 1 | 1 = handshake, 0 = no-handshake (wait-qualified) |
| wait_cnt | input | WAIT_W | Wait cycles before a no-handshake request is validated |
| stat_wr | input | 1 | Status write strobe; clears the pending bit |
| buf_load | input | 1 | A buffer has been programmed |
| buf_done | input | 1 | The active buffer has finished |
| req_sync | output | 1 | Synchronized request level |
| req_pending | output | 1 | Sticky request-pending status |
| buf_state | output | 2 | 00 none, 01 one loaded, 10 both loaded |
| next_flag | output | 1 | Buffer slot that will be loaded next |
| active_buf | output | 1 | Index of the active buffer |
| no_active | output | 1 | High when no buffer is active |

## Verification
The buffer logic is driven by a sequence of load pulses, done pulses, both together, and idle cycles. Together these reach every state with both values of the next-buffer flag, which separates a decode that reads only the state from one that uses both fields.

The request path is tried in three ways:
- A handshake edge, timed to the edge, which exposes a missing or extra synchronizer stage.
- A level held high after a clear, which separates edge detection from level sensing.
- No-handshake requests with a non-zero wait and with a zero wait, which expose an off-by-one in the counter.

A status write placed exactly in the cycle the edge is detected tells a set-wins priority apart from a clear-wins one.

// File: rtl/dreq_pkg.sv
// Package: shared types for the DMA request status tracker.
// Assumes the two-bit buffer-state encoding below is also what software reads.
package dreq_pkg;
    typedef enum logic [1:0] {
        BS_NONE = 2'b00,
        BS_ONE  = 2'b01,
        BS_BOTH = 2'b10
    } buf_state_e;
endpackage

// File: rtl/dreq_sync.sv
// Module: dreq_sync
// Two-flop synchronizer for the external request plus rising-edge detect
// on the synchronized level. Assumes req_async meets no timing to clk.
module dreq_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic req_level,
    output logic req_rise
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Synchronizer chain and delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= req_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Outputs: synchronized level and one-cycle rise pulse.
    always_comb begin
        req_level = sync_q;
        req_rise  = sync_q & ~prev_q;
    end
endmodule

// File: rtl/dreq_qualify.sv
// Module: dreq_qualify
// Turns request edges into the sticky pending bit. Handshake mode sets on
// the edge; no-handshake mode loads a wait counter and sets on expiry.
// Edges seen while pending or while waiting are ignored. Set beats clear.
module dreq_qualify #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rise,
    input  logic              hs_mode,
    input  logic [WAIT_W-1:0] wait_cnt,
    input  logic              clr,
    output logic              pending
);
    logic              running_q;
    logic [WAIT_W-1:0] cnt_q;
    logic              edge_ok;
    logic              expire;
    logic              set_evt;

    // Qualifying and setting conditions.
    always_comb begin
        edge_ok = req_rise & ~pending & ~running_q;
        expire  = running_q & (cnt_q == '0);
        set_evt = (edge_ok & hs_mode) | expire;
    end

    // Wait-state counter for no-handshake requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
        end else if (edge_ok && !hs_mode) begin
            running_q <= 1'b1;
            cnt_q     <= wait_cnt;
        end else if (running_q) begin
            if (cnt_q == '0) running_q <= 1'b0;
            else             cnt_q     <= cnt_q - 1'b1;
        end
    end

    // Sticky pending bit: set has priority over a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)       pending <= 1'b0;
        else if (set_evt) pending <= 1'b1;
        else if (clr)     pending <= 1'b0;
    end
endmodule

// File: rtl/buf_ring.sv
// Module: buf_ring
// Ping-pong buffer bookkeeping: state (none/one/both) and the slot to be
// loaded next. A done event is applied before a load event in one cycle.
module buf_ring
    import dreq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       done,
    output buf_state_e state,
    output logic       next_slot
);
    buf_state_e st_n;
    logic       nx_n;

    // Next-state: retire first, then accept a newly programmed buffer.
    always_comb begin
        st_n = state;
        nx_n = next_slot;
        if (done) begin
            case (state)
                BS_ONE:  st_n = BS_NONE;
                BS_BOTH: st_n = BS_ONE;
                default: st_n = state;
            endcase
        end
        if (load) begin
            case (st_n)
                BS_NONE: begin st_n = BS_ONE;  nx_n = ~nx_n; end
                BS_ONE:  begin st_n = BS_BOTH; nx_n = ~nx_n; end
                default: ;
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= BS_NONE;
            next_slot <= 1'b0;
        end else begin
            state     <= st_n;
            next_slot <= nx_n;
        end
    end
endmodule

// File: rtl/buf_decode.sv
// Module: buf_decode
// Derives the active buffer index from the buffer state and next slot.
// Assumes the encodings in dreq_pkg; an unused code behaves as "none".
module buf_decode
    import dreq_pkg::*;
(
    input  buf_state_e state,
    input  logic       next_slot,
    output logic       active,
    output logic       none
);
    // Combined decode of state and next-slot flag.
    always_comb begin
        case (state)
            BS_ONE:  begin active = ~next_slot; none = 1'b0; end
            BS_BOTH: begin active =  next_slot; none = 1'b0; end
            default: begin active = 1'b0;       none = 1'b1; end
        endcase
    end
endmodule

// File: rtl/dreq_status_tracker.sv
// Module: dreq_status_tracker (top)
// One channel's request capture, pending status and active-buffer report.
// Assumes a single clock domain apart from req_in, synchronous active-low reset.
module dreq_status_tracker
    import dreq_pkg::*;
#(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_in,
    input  logic              hs_mode,
    input  logic [WAIT_W-1:0] wait_cnt,
    input  logic              stat_wr,
    input  logic              buf_load,
    input  logic              buf_done,
    output logic              req_sync,
    output logic              req_pending,
    output logic [1:0]        buf_state,
    output logic              next_flag,
    output logic              active_buf,
    output logic              no_active
);
    logic       rise;
    buf_state_e st;

    dreq_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (req_in),
        .req_level (req_sync),
        .req_rise  (rise)
    );

    dreq_qualify #(.WAIT_W(WAIT_W)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_rise (rise),
        .hs_mode  (hs_mode),
        .wait_cnt (wait_cnt),
        .clr      (stat_wr),
        .pending  (req_pending)
    );

    buf_ring u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (buf_load),
        .done      (buf_done),
        .state     (st),
        .next_slot (next_flag)
    );

    buf_decode u_dec (
        .state     (st),
        .next_slot (next_flag),
        .active    (active_buf),
        .none      (no_active)
    );

    // Expose the buffer state as a plain vector.
    always_comb buf_state = st;
endmodule

// File: rtl/dreq_status_checker.sv
// Module: dreq_status_checker
// Concurrent checks on the tracker's ports, bound into every instance.
module dreq_status_checker #(
    parameter int WAIT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_in,
    input logic              hs_mode,
    input logic [WAIT_W-1:0] wait_cnt,
    input logic              stat_wr,
    input logic              buf_load,
    input logic              buf_done,
    input logic              req_sync,
    input logic              req_pending,
    input logic [1:0]        buf_state,
    input logic              next_flag,
    input logic              active_buf,
    input logic              no_active
);
    AST_ONE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_state == 2'b01) |-> (active_buf == !next_flag)); // R2
    AST_BOTH_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_state == 2'b10) |-> (active_buf == next_flag)); // R3
    AST_NONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        no_active == ((buf_state == 2'b00) && !active_buf)); // R4
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        buf_state != 2'b11); // R5
    AST_FALL_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_pending) |-> $past(stat_wr)); // R6
    AST_WRITE_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !buf_load && !buf_done) |=> ($stable(buf_state) && $stable(next_flag))); // R7
    AST_HS_SET_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_pending) && $past(hs_mode)) |-> $past(req_sync)); // R1
endmodule

bind dreq_status_tracker dreq_status_checker #(.WAIT_W(WAIT_W)) u_chk (.*);

// File: tb/dreq_status_tracker_tb.sv
module dreq_status_tracker_tb;
    localparam int WAIT_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_in = 1'b0;
    logic              hs_mode = 1'b1;
    logic [WAIT_W-1:0] wait_cnt = '0;
    logic              stat_wr = 1'b0;
    logic              buf_load = 1'b0;
    logic              buf_done = 1'b0;
    logic              req_sync, req_pending, next_flag, active_buf, no_active;
    logic [1:0]        buf_state;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;  // 50 MHz

    dreq_status_tracker #(.WAIT_W(WAIT_W)) u_dut (.*);

    // Row: {load, done, exp_state[1:0], exp_next, exp_active, exp_none}
    localparam int NV = 12;
    localparam logic [6:0] VEC [NV] = '{
        7'b10_01_1_0_0, 7'b10_10_0_0_0, 7'b10_10_0_0_0, 7'b01_01_0_1_0,
        7'b11_01_1_0_0, 7'b10_10_0_0_0, 7'b11_10_1_1_0, 7'b01_01_1_0_0,
        7'b01_00_1_0_1, 7'b10_01_0_1_0, 7'b00_01_0_1_0, 7'b01_00_0_0_1
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_pending();
        @(negedge clk); stat_wr = 1'b1;
        @(negedge clk); stat_wr = 1'b0;
    endtask

    task automatic drop_req();
        @(negedge clk); req_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 pending", req_pending, 0);
        chk("R10 sync", req_sync, 0);
        chk("R10 state", buf_state, 0);
        chk("R10 next", next_flag, 0);
        chk("R10 active", active_buf, 0);
        chk("R10 none", no_active, 1);

        // Buffer sequencing table: R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            buf_load = VEC[i][6];
            buf_done = VEC[i][5];
            @(negedge clk);
            buf_load = 1'b0; buf_done = 1'b0;
            chk("R5 state", buf_state, VEC[i][4:3]);
            chk("R5 next", next_flag, VEC[i][2]);
            chk("R2/R3 active", active_buf, VEC[i][1]);
            chk("R4 none", no_active, VEC[i][0]);
        end
        // Leave the ring in state 01 for the write checks below.
        buf_load = 1'b1; @(negedge clk); buf_load = 1'b0;

        // R1 handshake timing
        hs_mode = 1'b1;
        req_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 pending after 2 edges", req_pending, 0);
        @(negedge clk);
        chk("R1 pending after 3 edges", req_pending, 1);

        // R6 clear, R7 other fields untouched
        clear_pending();
        chk("R6 cleared", req_pending, 0);
        chk("R7 sync kept", req_sync, 1);
        chk("R7 state kept", buf_state, 1);
        chk("R7 next kept", next_flag, 1);
        chk("R7 active kept", active_buf, 0);

        // R8 held level does not re-set
        repeat (5) @(negedge clk);
        chk("R8 level ignored", req_pending, 0);

        // R6 set wins over a same-cycle write
        drop_req();
        req_in = 1'b1;
        repeat (2) @(negedge clk);
        stat_wr = 1'b1;
        @(negedge clk); stat_wr = 1'b0;
        chk("R6 set wins", req_pending, 1);
        clear_pending();
        drop_req();

        // R9 no-handshake, wait 3
        hs_mode = 1'b0; wait_cnt = 8'd3;
        req_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 sync high during wait", req_sync, 1);
        chk("R9 held at edge 3", req_pending, 0);
        repeat (3) @(negedge clk);
        chk("R9 held at edge 3+W", req_pending, 0);
        @(negedge clk);
        chk("R9 set at edge 4+W", req_pending, 1);
        clear_pending();
        drop_req();

        // R9 no-handshake, wait 0
        wait_cnt = 8'd0;
        req_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 W0 held at edge 3", req_pending, 0);
        @(negedge clk);
        chk("R9 W0 set at edge 4", req_pending, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule